// File: doc/BRIEF.md
# IDE Register Window on a Memory-Mapped Bus

This block sits between a memory-mapped bus and a disk controller's register set. Registers are spread across the address space with a 16-byte spacing. The block takes the register index from the bus offset. It forwards data-port, task-file and status/command accesses to a plain register port on the IDE side. It also answers two accesses itself: a timing register, and an interrupt-state word.

The bus port finishes every access in one cycle. Read data and IDE-side strobes are combinational from the bus request, and register updates take effect at the next clock edge. Each access carries a byte count of 1, 2 or 4. Data is little-endian and right-aligned, so it passes through without any byte swapping. The interrupt-state word combines two things. One is a sticky DMA-complete flag that software clears by writing a 1. The other is a live copy of the disk interrupt line.

Top module: `ide_mmio_window`

## Requirements
- R1: The register index is bus_addr[11:4]. Address bits [3:0] and any bits above bit 11 do not affect decoding.
- R2: Index 0x00 is the data port. A 2-byte or 4-byte access drives ide_addr=0 with a one-cycle ide_rd or ide_wr strobe. An access of any other size gives no strobe, and a read of it returns 0xFFFFFFFF.
- R3: Indices 0x01 to 0x07 forward reads and writes of any legal size to ide_addr equal to the index. bus_rdata is taken from ide_rdata, and ide_wdata carries bus_wdata.
- R4: Indices 0x08 and 0x16 both map to ide_addr=8. A read there returns drive status, and a write there is a command write.
- R5: Index 0x20 is a 32-bit timing register. A 4-byte write stores bus_wdata, and the value reads back at any legal size. A write of any other size leaves it unchanged. Accesses to it never strobe the IDE side.
- R6: Index 0x30 bit 31 is set by a dma_irq pulse and stays set. A 4-byte write to index 0x30 with bit 31 = 1 clears it. A write with bit 31 = 0, or a write of a size other than 4, leaves it unchanged.
- R7: When a dma_irq pulse and a clearing write happen in the same cycle, bit 31 ends up set.
- R8: Index 0x30 bit 30 equals disk_irq in the same cycle, and is not stored. Bits 29:0 read as zero.
- R9: Any index not listed above reads 0xFFFFFFFF, produces no IDE strobe, and changes no stored state.
- R10: A bus_size value other than 1, 2 or 4 produces no strobe and no state change, and its read returns 0xFFFFFFFF.
- R11: After reset, the timing register reads 0 and bit 31 of index 0x30 reads 0.
- R12: ide_rd and ide_wr are never high together, and never high without bus_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Bus access present this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW (16) | Byte offset within the window |
| bus_size | input | 3 | Access size in bytes (1, 2 or 4 legal) |
| bus_wdata | input | DW (32) | Write data, little-endian, right-aligned |
| bus_rdata | output | DW (32) | Read data, combinational |
| ide_addr | output | 4 | IDE register number (0 data, 1-7 task file, 8 status/command) |
| ide_rd | output | 1 | IDE read strobe |
| ide_wr | output | 1 | IDE write strobe |
| ide_wdata | output | DW (32) | IDE write data |
| ide_rdata | input | DW (32) | IDE read data |
| dma_irq | input | 1 | DMA-complete pulse |
| disk_irq | input | 1 | Disk interrupt level |

## Verification
Every index from 0 to 255 is tried with every bus_size code from 0 to 7, both as a read and as a write. The offset bits outside the index field change from one access to the next. This sweep separates the five outcomes from each other: forwarded with the right IDE register number, data port refused because of size, local register hit, undefined index, and illegal size. It also shows that the ignored address bits have no effect. The bench keeps its own model of the timing register, updated only on 4-byte writes, so a write of the wrong size that changes the register shows up in a later read. Directed sequences then exercise the DMA flag: setting it, a clearing write with bit 31 = 0, a clearing write of the wrong size, a true clear, and a pulse in the same cycle as a clear. These sequences also toggle disk_irq to check the live bit 30.

// File: rtl/ide_win_pkg.sv
package ide_win_pkg;

  localparam int IDX_W = 8;

  localparam logic [IDX_W-1:0] IDX_DATA     = 8'h00;
  localparam logic [IDX_W-1:0] IDX_TF_LAST  = 8'h07;
  localparam logic [IDX_W-1:0] IDX_STAT     = 8'h08;
  localparam logic [IDX_W-1:0] IDX_STAT_ALT = 8'h16;
  localparam logic [IDX_W-1:0] IDX_TIMING   = 8'h20;
  localparam logic [IDX_W-1:0] IDX_IRQ      = 8'h30;

  localparam logic [3:0] PORT_STATUS = 4'h8;

  typedef struct packed {
    logic       fwd;
    logic [3:0] port;
  } route_t;

  // 1, 2 or 4 bytes
  function automatic logic size_legal(input logic [2:0] sz);
    return (sz == 3'd1) || (sz == 3'd2) || (sz == 3'd4);
  endfunction

  // data port accepts halfword and word only
  function automatic logic size_wide(input logic [2:0] sz);
    return (sz == 3'd2) || (sz == 3'd4);
  endfunction

  function automatic route_t route_of(input logic [IDX_W-1:0] idx,
                                      input logic [2:0] sz);
    route_t r;
    r.fwd  = 1'b0;
    r.port = 4'h0;
    if (idx == IDX_DATA) begin
      r.fwd  = size_wide(sz);
      r.port = 4'h0;
    end else if (idx <= IDX_TF_LAST) begin
      r.fwd  = size_legal(sz);
      r.port = idx[3:0];
    end else if ((idx == IDX_STAT) || (idx == IDX_STAT_ALT)) begin
      r.fwd  = size_legal(sz);
      r.port = PORT_STATUS;
    end
    return r;
  endfunction

endpackage

// File: rtl/ide_win_decode.sv
module ide_win_decode
  import ide_win_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic [AW-1:0]    addr,
  input  logic [2:0]       size,
  output logic [IDX_W-1:0] idx,
  output route_t           route,
  output logic             hit_timing,
  output logic             hit_irq,
  output logic             sz_ok,
  output logic             sz_word
);
  localparam int IDX_LO = 4;
  localparam int IDX_HI = IDX_LO + IDX_W - 1;

  always_comb begin
    idx        = addr[IDX_HI:IDX_LO];
    route      = route_of(idx, size);
    sz_ok      = size_legal(size);
    sz_word    = (size == 3'd4);
    hit_timing = (idx == IDX_TIMING);
    hit_irq    = (idx == IDX_IRQ);
  end

endmodule

// File: rtl/ide_win_timing.sv
module ide_win_timing #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [DW-1:0] d,
  output logic [DW-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else if (we) q <= d;
  end

  AST_TMG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(q)); // R5

endmodule

// File: rtl/ide_win_irq.sv
module ide_win_irq #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dma_pulse,
  input  logic          disk_lvl,
  input  logic          clr_req,
  output logic [DW-1:0] value
);
  localparam int DMA_BIT  = DW - 1;
  localparam int DISK_BIT = DW - 2;

  logic dma_flag;

  // a new pulse beats a simultaneous clear
  always_ff @(posedge clk) begin
    if (!rst_n)         dma_flag <= 1'b0;
    else if (dma_pulse) dma_flag <= 1'b1;
    else if (clr_req)   dma_flag <= 1'b0;
  end

  always_comb begin
    value           = '0;
    value[DMA_BIT]  = dma_flag;
    value[DISK_BIT] = disk_lvl;
  end

  AST_DMA_SET: assert property (@(posedge clk) disable iff (!rst_n)
    dma_pulse |=> dma_flag); // R7
  AST_DMA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_flag && !clr_req) |=> dma_flag); // R6
  AST_DMA_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && !dma_pulse) |=> !dma_flag); // R6

endmodule

// File: rtl/ide_mmio_window.sv
module ide_mmio_window
  import ide_win_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_valid,
  input  logic          bus_write,
  input  logic [AW-1:0] bus_addr,
  input  logic [2:0]    bus_size,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic [3:0]    ide_addr,
  output logic          ide_rd,
  output logic          ide_wr,
  output logic [DW-1:0] ide_wdata,
  input  logic [DW-1:0] ide_rdata,
  input  logic          dma_irq,
  input  logic          disk_irq
);
  localparam int CLR_BIT = DW - 1;

  logic [IDX_W-1:0] idx;
  route_t           route;
  logic             hit_timing, hit_irq, sz_ok, sz_word;
  logic             acc_rd, acc_wr;
  logic             timing_we, irq_clr;
  logic [DW-1:0]    timing_q, irq_word;

  ide_win_decode #(.AW(AW)) u_dec (
    .addr       (bus_addr),
    .size       (bus_size),
    .idx        (idx),
    .route      (route),
    .hit_timing (hit_timing),
    .hit_irq    (hit_irq),
    .sz_ok      (sz_ok),
    .sz_word    (sz_word)
  );

  assign acc_rd    = bus_valid && !bus_write;
  assign acc_wr    = bus_valid && bus_write;
  assign timing_we = acc_wr && hit_timing && sz_word;
  assign irq_clr   = acc_wr && hit_irq && sz_word && bus_wdata[CLR_BIT];

  ide_win_timing #(.DW(DW)) u_tmg (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (timing_we),
    .d     (bus_wdata),
    .q     (timing_q)
  );

  ide_win_irq #(.DW(DW)) u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .dma_pulse (dma_irq),
    .disk_lvl  (disk_irq),
    .clr_req   (irq_clr),
    .value     (irq_word)
  );

  assign ide_addr  = route.port;
  assign ide_rd    = acc_rd && route.fwd;
  assign ide_wr    = acc_wr && route.fwd;
  assign ide_wdata = bus_wdata;

  always_comb begin
    if (route.fwd)                bus_rdata = ide_rdata;
    else if (hit_timing && sz_ok) bus_rdata = timing_q;
    else if (hit_irq && sz_ok)    bus_rdata = irq_word;
    else                          bus_rdata = '1;
  end

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(ide_rd && ide_wr)); // R12
  AST_STROBE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (ide_rd || ide_wr) |-> bus_valid); // R12
  AST_DATA_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
    ((ide_rd || ide_wr) && ide_addr == 4'h0) |-> (bus_size == 3'd2 || bus_size == 3'd4)); // R2
  AST_STATUS_ALIAS: assert property (@(posedge clk) disable iff (!rst_n)
    ((ide_rd || ide_wr) && ide_addr == PORT_STATUS) |->
      (bus_addr[11:4] == IDX_STAT || bus_addr[11:4] == IDX_STAT_ALT)); // R4
  AST_SIZE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (ide_rd || ide_wr) |-> (bus_size == 3'd1 || bus_size == 3'd2 || bus_size == 3'd4)); // R10

endmodule

// File: tb/ide_mmio_window_bench.sv
`timescale 1ns/1ps
module ide_mmio_window_bench;
  localparam int AW = 16;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_valid = 1'b0, bus_write = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [2:0]    bus_size = 3'd4;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic [3:0]    ide_addr;
  logic          ide_rd, ide_wr;
  logic [DW-1:0] ide_wdata, ide_rdata;
  logic          dma_irq = 1'b0, disk_irq = 1'b0;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [31:0] tmg_m = 32'h0;
  bit          dma_m = 0;

  always #10 clk = ~clk;

  // IDE side echoes its register number in the low nibble
  assign ide_rdata = 32'h5AC3_0000 | {28'h0, ide_addr};

  ide_mmio_window #(.AW(AW), .DW(DW)) u_ide_mmio_window (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .ide_addr(ide_addr), .ide_rd(ide_rd),
    .ide_wr(ide_wr), .ide_wdata(ide_wdata), .ide_rdata(ide_rdata),
    .dma_irq(dma_irq), .disk_irq(disk_irq)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic bit legal(input int sz);
    return sz == 1 || sz == 2 || sz == 4;
  endfunction

  // expected forwarding: returns port in [3:0], forward flag in [4]
  function automatic logic [4:0] exp_fwd(input int idx, input int sz);
    if (idx == 0) return {((sz == 2) || (sz == 4)) ? 1'b1 : 1'b0, 4'h0};
    if (idx >= 1 && idx <= 7) return {legal(sz) ? 1'b1 : 1'b0, 4'(idx)};
    if (idx == 8 || idx == 22) return {legal(sz) ? 1'b1 : 1'b0, 4'h8};
    return 5'h0;
  endfunction

  function automatic string tag_of(input int idx, input int sz);
    if (!legal(sz)) return "R10";
    if (idx == 0) return "R2";
    if (idx <= 7) return "R3";
    if (idx == 8 || idx == 22) return "R4";
    if (idx == 32) return "R5";
    if (idx == 48) return "R8";
    return "R9";
  endfunction

  function automatic logic [31:0] exp_rd(input int idx, input int sz);
    logic [4:0] f = exp_fwd(idx, sz);
    if (f[4]) return 32'h5AC3_0000 | {28'h0, f[3:0]};
    if (idx == 32 && legal(sz)) return tmg_m;
    if (idx == 48 && legal(sz)) return {dma_m, disk_irq, 30'h0};
    return 32'hFFFF_FFFF;
  endfunction

  // one bus access; outputs checked before the closing edge
  task automatic probe(input bit wr, input int idx, input int sz,
                       input logic [31:0] wd, input logic [15:0] addr,
                       input string tg);
    logic [4:0] f;
    logic [31:0] er;
    @(negedge clk);
    bus_valid = 1'b1; bus_write = wr; bus_addr = addr;
    bus_size = 3'(sz); bus_wdata = wd;
    #2;
    f  = exp_fwd(idx, sz);
    er = exp_rd(idx, sz);
    chk(ide_rd == (f[4] && !wr) && ide_wr == (f[4] && wr), tg,
        {30'h0, ide_rd, ide_wr}, {30'h0, f[4] && !wr, f[4] && wr});
    if (f[4]) chk(ide_addr == f[3:0] && ide_wdata == wd, tg,
                  {ide_addr, ide_wdata[27:0]}, {f[3:0], wd[27:0]});
    if (!wr) chk(bus_rdata == er, tg, bus_rdata, er);
    @(posedge clk);
    #1;
    bus_valid = 1'b0; bus_write = 1'b0;
    if (wr && idx == 32 && sz == 4) tmg_m = wd;
    if (wr && idx == 48 && sz == 4 && wd[31]) dma_m = 0;
  endtask

  task automatic pulse_dma();
    @(negedge clk); dma_irq = 1'b1;
    @(negedge clk); dma_irq = 1'b0;
    dma_m = 1;
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog act=0 exp=1");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R11 reset state
    probe(0, 32, 4, 0, 16'h0200, "R11");
    probe(0, 48, 4, 0, 16'h0300, "R11");

    // R1: stray address bits do not disturb decoding
    probe(1, 32, 4, 32'h1234_5678, 16'hF20F, "R1");
    probe(0, 32, 4, 0, 16'hA205, "R1");
    probe(0, 3, 1, 0, 16'h703C, "R1");

    // full sweep of index x size, read then write
    for (int idx = 0; idx < 256; idx++) begin
      for (int sz = 0; sz < 8; sz++) begin
        logic [15:0] a;
        logic [31:0] wd;
        a  = {4'(idx ^ sz), 8'(idx), 4'(idx + sz)};
        wd = {1'b0, 31'(idx * 32'h0101_0103 + sz * 32'h0011_0007)};
        probe(0, idx, sz, 0, a, tag_of(idx, sz));
        probe(1, idx, sz, wd, a, tag_of(idx, sz));
        if (idx == 32) probe(0, 32, 4, 0, 16'h0200, "R5");
      end
    end
    probe(0, 32, 2, 0, 16'h0200, "R5");

    // R8 live disk bit
    @(negedge clk); disk_irq = 1'b1;
    probe(0, 48, 4, 0, 16'h0300, "R8");
    @(negedge clk); disk_irq = 1'b0;
    probe(0, 48, 1, 0, 16'h0300, "R8");

    // R6 latch, non-clearing writes, real clear
    pulse_dma();
    repeat (3) @(posedge clk);
    probe(0, 48, 4, 0, 16'h0300, "R6");
    probe(1, 48, 4, 32'h7FFF_FFFF, 16'h0300, "R6");
    probe(0, 48, 4, 0, 16'h0300, "R6");
    probe(1, 48, 2, 32'h8000_0000, 16'h0300, "R6");
    probe(0, 48, 4, 0, 16'h0300, "R6");
    probe(1, 48, 4, 32'h8000_0000, 16'h0300, "R6");
    probe(0, 48, 4, 0, 16'h0300, "R6");

    // R7 pulse and clear together: set wins
    @(negedge clk);
    dma_irq = 1'b1; bus_valid = 1'b1; bus_write = 1'b1;
    bus_addr = 16'h0300; bus_size = 3'd4; bus_wdata = 32'h8000_0000;
    @(posedge clk); #1;
    dma_irq = 1'b0; bus_valid = 1'b0; bus_write = 1'b0;
    dma_m = 1;
    probe(0, 48, 4, 0, 16'h0300, "R7");
    // R12 idle bus gives no strobe
    @(negedge clk); #2;
    chk(!ide_rd && !ide_wr, "R12", {30'h0, ide_rd, ide_wr}, 32'h0);

    done = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule